// File: doc/BRIEF.md
# Multi-channel IR beacon encoder

This block drives the infrared beacons of a robot charging base. Each channel sends its own 8-bit identifier again and again, one word per 40 ms frame. A bit is sent as a 4 ms symbol with one 3 ms phase and one 1 ms phase. The order of those two phases carries the bit value. The last 8 ms of every frame are dark.

While the envelope is high, the drive line does not sit at a steady level. It toggles as a carrier square wave, made by dividing the system clock, with roughly 65% high time. The nominal settings are 38 kHz and codes of 0xF4 for the right-side beacon and 0xF2 for the force-field beacon.

A docked flag silences every channel while the robot sits on the base. The docked flag and the code inputs take effect only at a frame boundary, so a word is never cut short. All control pins are plain levels. There is no streaming interface, so no valid/ready rules apply.

Top module: `ir_beacon_enc`

## Requirements
- R1: While `rst` is high, every `beacon_out` bit is 0 one clock after each reset edge.
- R2: A frame lasts FRAME_MS (40) milliseconds of MS_CYC clocks each and holds 10 symbol slots of SYM_MS (4) ms. Slots 0 to 7 carry the code MSB first, so bit 7 is in milliseconds 0 to 3 of the frame.
- R3: For a 1 bit, the envelope is high in the first 3 ms of its symbol and low in the last ms.
- R4: For a 0 bit, the envelope is low in the first ms of its symbol and high in the remaining 3 ms.
- R5: Milliseconds 32 to 39 of every frame are dark on every channel.
- R6: The carrier counts clocks from reset modulo CAR_PERIOD and is high for counts below CAR_HIGH. A drive line is the envelope AND the carrier AND not-muted.
- R7: `docked` is sampled at the last clock of each frame (and during reset). When the sampled value is 1, all outputs stay 0 for the whole next frame. A change in mid-frame does not alter the current frame.
- R8: The codes are sampled at the same instants as `docked`. A code change in mid-frame leaves the word being sent unchanged.
- R9: Channel i sends `codes[8i+7:8i]`, independently of the other channels.
- R10: Outputs are registered. The value after clock edge k reflects frame position k-1, counted from the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| codes | input | NCH*CODE_W | Per-channel identifier, channel i in slice i |
| docked | input | 1 | Robot on base; mutes all channels from the next frame |
| beacon_out | output | NCH | Gated carrier drive, one per channel |

## Verification
The hardest situations to reach are changes of `docked` and of the codes that land inside a frame. The bench must show that these changes alter nothing until the next boundary, and that a mid-frame reset restarts the frame grid. The stimulus therefore flips the codes in mid-frame, asserts docked in one frame and releases it two frames later, and then resets part-way through a frame. A cycle-exact arithmetic model is compared on every clock, and each frame is also decoded by sampling the activity at the symbol midpoint and in its final millisecond.

// File: rtl/ir_beacon_pkg.sv
package ir_beacon_pkg;
  // Envelope level of one symbol: a 1 bit leads with the long high phase,
  // a 0 bit leads with the short low phase.
  function automatic logic sym_level(input logic bit_val, input int unsigned ph,
                                     input int unsigned hi_ms, input int unsigned sym_ms);
    if (bit_val) return ph < hi_ms;
    return ph >= (sym_ms - hi_ms);
  endfunction
endpackage

// File: rtl/ir_beacon_timebase.sv
module ir_beacon_timebase #(
  parameter int MS_CYC   = 50000,
  parameter int SYM_MS   = 4,
  parameter int FRAME_MS = 40,
  parameter int CODE_W   = 8
) (
  input  logic clk,
  input  logic rst,
  output logic [$clog2(SYM_MS)-1:0] phase,
  output logic [$clog2(FRAME_MS/SYM_MS)-1:0] slot,
  output logic idle,
  output logic frame_end
);
  localparam int SLOTS = FRAME_MS / SYM_MS;
  localparam int CW = $clog2(MS_CYC);
  localparam int PW = $clog2(SYM_MS);
  localparam int SW = $clog2(SLOTS);
  localparam logic [CW-1:0] MS_LAST   = CW'(MS_CYC - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(SYM_MS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] FIRST_IDLE = SW'(CODE_W);

  logic [CW-1:0] cyc;
  logic ms_end, sym_end;

  assign ms_end    = (cyc == MS_LAST);
  assign sym_end   = ms_end && (phase == PH_LAST);
  assign frame_end = sym_end && (slot == SLOT_LAST);
  assign idle      = (slot >= FIRST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc   <= '0;
      phase <= '0;
      slot  <= '0;
    end else begin
      cyc <= ms_end ? '0 : cyc + 1'b1;
      if (ms_end) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (sym_end) slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end
  end
endmodule

// File: rtl/ir_beacon_carrier.sv
module ir_beacon_carrier #(
  parameter int CAR_PERIOD = 1316,
  parameter int CAR_HIGH   = 855
) (
  input  logic clk,
  input  logic rst,
  output logic car_on
);
  localparam int KW = $clog2(CAR_PERIOD);
  localparam logic [KW-1:0] K_LAST = KW'(CAR_PERIOD - 1);
  localparam logic [KW-1:0] K_HIGH = KW'(CAR_HIGH);

  logic [KW-1:0] cnt;

  assign car_on = (cnt < K_HIGH);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= (cnt == K_LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ir_beacon_channel.sv
module ir_beacon_channel
  import ir_beacon_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SYM_MS   = 4,
  parameter int HI_MS    = 3,
  parameter int FRAME_MS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic load,
  input  logic [$clog2(SYM_MS)-1:0] phase,
  input  logic [$clog2(FRAME_MS/SYM_MS)-1:0] slot,
  input  logic idle,
  input  logic car_on,
  input  logic mute,
  output logic drive
);
  localparam int IW = $clog2(CODE_W);
  localparam logic [IW-1:0] TOP_IDX = IW'(CODE_W - 1);

  logic [CODE_W-1:0] code_q;
  logic bit_val, env;

  assign bit_val = code_q[TOP_IDX - IW'(slot)];
  assign env = !idle && sym_level(bit_val, 32'(phase), HI_MS, SYM_MS);

  always_ff @(posedge clk) begin
    if (rst || load) code_q <= code_in;
    if (rst) drive <= 1'b0;
    else     drive <= env && car_on && !mute;
  end
endmodule

// File: rtl/ir_beacon_enc.sv
module ir_beacon_enc #(
  parameter int NCH        = 2,
  parameter int CODE_W     = 8,
  parameter int MS_CYC     = 50000,
  parameter int SYM_MS     = 4,
  parameter int HI_MS      = 3,
  parameter int FRAME_MS   = 40,
  parameter int CAR_PERIOD = 1316,
  parameter int CAR_HIGH   = 855
) (
  input  logic clk,
  input  logic rst,
  input  logic [NCH*CODE_W-1:0] codes,
  input  logic docked,
  output logic [NCH-1:0] beacon_out
);
  localparam int PW = $clog2(SYM_MS);
  localparam int SW = $clog2(FRAME_MS / SYM_MS);

  logic [PW-1:0] phase;
  logic [SW-1:0] slot;
  logic idle, frame_end, car_on, dock_q;

  ir_beacon_timebase #(
    .MS_CYC(MS_CYC), .SYM_MS(SYM_MS), .FRAME_MS(FRAME_MS), .CODE_W(CODE_W)
  ) u_tb (
    .clk(clk), .rst(rst), .phase(phase), .slot(slot),
    .idle(idle), .frame_end(frame_end)
  );

  ir_beacon_carrier #(.CAR_PERIOD(CAR_PERIOD), .CAR_HIGH(CAR_HIGH)) u_car (
    .clk(clk), .rst(rst), .car_on(car_on)
  );

  // Mute decision only moves at a frame boundary.
  always_ff @(posedge clk) begin
    if (rst || frame_end) dock_q <= docked;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ir_beacon_channel #(
      .CODE_W(CODE_W), .SYM_MS(SYM_MS), .HI_MS(HI_MS), .FRAME_MS(FRAME_MS)
    ) u_ch (
      .clk(clk), .rst(rst), .code_in(codes[i*CODE_W +: CODE_W]),
      .load(frame_end), .phase(phase), .slot(slot), .idle(idle),
      .car_on(car_on), .mute(dock_q), .drive(beacon_out[i])
    );
  end
endmodule

// File: rtl/ir_beacon_enc_chk.sv
module ir_beacon_enc_chk #(
  parameter int NCH = 2
) (
  input logic clk,
  input logic rst,
  input logic [NCH-1:0] beacon_out,
  input logic car_on,
  input logic idle,
  input logic dock_q,
  input logic frame_end
);
  AST_RESET_DARK: assert property (@(posedge clk) rst |=> beacon_out == '0); // R1
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    idle |=> beacon_out == '0); // R5
  AST_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (rst)
    (beacon_out != '0) |-> $past(car_on)); // R6
  AST_DOCK_DARK: assert property (@(posedge clk) disable iff (rst)
    dock_q |=> beacon_out == '0); // R7
  AST_DOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(dock_q)); // R7
endmodule

bind ir_beacon_enc ir_beacon_enc_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .beacon_out(beacon_out), .car_on(car_on),
  .idle(idle), .dock_q(dock_q), .frame_end(frame_end)
);

// File: tb/ir_beacon_enc_bench.sv
module ir_beacon_enc_bench;
  localparam int NCH = 2;
  localparam int MS  = 40;
  localparam int CP  = 8;
  localparam int CH  = 5;
  localparam int F   = MS * 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] codes = {8'hF2, 8'hF4};
  logic docked = 1'b0;
  logic [NCH-1:0] bo;

  always #2 clk = ~clk;

  ir_beacon_enc #(
    .NCH(NCH), .CODE_W(8), .MS_CYC(MS), .SYM_MS(4), .HI_MS(3),
    .FRAME_MS(40), .CAR_PERIOD(CP), .CAR_HIGH(CH)
  ) u_ir_beacon_enc (
    .clk(clk), .rst(rst), .codes(codes), .docked(docked), .beacon_out(bo)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int k;
  logic [7:0] cm [NCH];
  logic dm;
  logic [39:0] act [NCH];
  bit changed;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic logic expv(input int t, input logic [7:0] c, input logic d);
    int tf = t % F;
    int ms = tf / MS;
    int ph = ms % 4;
    logic car = (t % CP) < CH;
    logic b;
    if (d || ms >= 32) return 1'b0;
    b = c[7 - ms / 4];
    return car && (b ? (ph < 3) : (ph >= 1));
  endfunction

  function automatic string tagof(input int t, input logic [7:0] c, input logic d);
    int ms = (t % F) / MS;
    int ph = ms % 4;
    logic b;
    if (d) return "R7";
    if (ms >= 32) return "R5";
    b = c[7 - ms / 4];
    if ((t % CP) >= CH && (b ? (ph < 3) : (ph >= 1))) return "R6";
    return b ? "R3" : "R4";
  endfunction

  task automatic load_model();
    for (int c = 0; c < NCH; c++) begin
      cm[c] = codes[c*8 +: 8];
      act[c] = '0;
    end
    dm = docked;
    changed = 1'b0;
    k = 0;
  endtask

  task automatic step();
    int t, tf;
    logic e;
    @(posedge clk);
    #1;
    k++;
    t = k - 1;
    tf = t % F;
    for (int c = 0; c < NCH; c++) begin
      e = expv(t, cm[c], dm);
      chk(bo[c] == e, tagof(t, cm[c], dm), $sformatf("ch%0d t=%0d R10", c, t), bo[c], e);
      if (bo[c]) act[c][tf / MS] = 1'b1;
    end
    if (tf == F - 1) begin
      for (int c = 0; c < NCH; c++) begin
        if (dm) begin
          chk(act[c] == '0, "R7", $sformatf("ch%0d docked frame activity", c), 0, 0);
        end else begin
          logic [7:0] w;
          logic [7:0] mid;
          for (int b = 0; b < 8; b++) begin
            w[7 - b]   = !act[c][4*b + 3];
            mid[7 - b] = act[c][4*b + 2];
          end
          chk(w == cm[c], changed ? "R8" : (c == 1 ? "R9" : "R2"),
              $sformatf("ch%0d decoded word", c), w, cm[c]);
          chk(mid == 8'hFF, "R2", $sformatf("ch%0d midpoint envelope", c), mid, 8'hFF);
          chk(act[c][39:32] == '0, "R5", $sformatf("ch%0d idle tail", c), act[c][39:32], 0);
        end
        act[c] = '0;
      end
      for (int c = 0; c < NCH; c++) cm[c] = codes[c*8 +: 8];
      dm = docked;
      changed = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(bo == '0, "R1", "outputs in reset", bo, 0);
    rst = 1'b0;
    load_model();
    for (int n = 0; n < 8 * F; n++) begin
      step();
      if (k == F + 700) begin
        codes = {8'hFF, 8'h00};
        changed = 1'b1;
      end
      if (k == 3 * F + 500) begin
        codes = {8'h5A, 8'hA5};
        changed = 1'b1;
      end
      if (k == 3 * F + 800) docked = 1'b1;
      if (k == 5 * F + 300) docked = 1'b0;
    end
    // Reset in mid-frame restarts the grid.
    repeat (700) step();
    rst = 1'b1;
    codes = {8'hF2, 8'hF4};
    @(posedge clk);
    #1;
    chk(bo == '0, "R1", "outputs after mid-frame reset", bo, 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    load_model();
    for (int n = 0; n < 2 * F; n++) step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule